// File: doc/BRIEF.md
# Display Identification Serial Sender

This block streams display identification bytes to a host over a single data line. The host supplies the bit clock on `vclk_i`, and that clock is asynchronous to the system clock. After the block is enabled, it waits through a nine-clock synchronization preamble with the data line released. It then sends one byte per nine `vclk_i` rising edges. Each byte is eight data bits, most significant first, followed by a slot in which the line is released while the next byte is made ready. The line is modelled as an output enable plus a data bit.

Bytes come from an internal 256-entry buffer addressed by an auto-incrementing pointer. The pointer wraps at 128 or at 256 entries, as `ext_size_i` selects. In hardware mode the block refills itself from the buffer. In software mode an interrupt asks a local controller to write each byte through a small register port. That port also reaches the pointer, the buffer through the pointer with post-increment, and the buffer by direct address.

Top module: `edid_serial_tx`

## Requirements
- R1: While `en_i` is low, `sda_oe_o` is low.
- R2: After `en_i` rises, `sda_oe_o` stays low for the first 9 `vclk_i` rising edges. The first data bit is driven at the 10th rising edge.
- R3: Each byte is driven as 8 bits, one per `vclk_i` rising edge, bit 7 first. `sda_do_o` holds its value between rising edges.
- R4: The 9th rising edge of every byte slot releases the line (`sda_oe_o` low).
- R5: In hardware mode (`sw_mode_i`=0), the bytes sent are the buffer entries at consecutive pointer values, starting at the pointer value held when the block was enabled. The pointer advances by one for each byte fetched.
- R6: Pointer increments are masked to 7 bits when `ext_size_i`=0, so 127 is followed by 0. They are masked to 8 bits when `ext_size_i`=1, so 255 is followed by 0.
- R7: In software mode, `irq_o` is set at the 9th preamble edge and at every released slot. It stays set until `irq_clr_i` is pulsed, and it is cleared while disabled.
- R8: In software mode while enabled, a hold write (`hst_kind_i`=0, write) supplies the byte sent in the next byte slot.
- R9: In software mode, if no hold write occurs between two byte starts, the previous hold value is sent again and `underrun_o` is set. `underrun_o` stays set until `en_i` goes low.
- R10: A pointer write (`hst_kind_i`=1) stores the data masked as in R6 while disabled or in software mode. It is ignored while enabled in hardware mode. A pointer read returns the pointer.
- R11: A buffer access through the pointer (`hst_kind_i`=2), allowed while disabled or in software mode, reads or writes the entry at the pointer and then post-increments the pointer as in R6.
- R12: A direct buffer access (`hst_kind_i`=3) reads or writes the entry at `hst_addr_i` and leaves the pointer unchanged.
- R13: After reset the pointer is 0 and `irq_o`, `underrun_o` and `sda_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vclk_i | input | 1 | Host-supplied bit clock, asynchronous |
| en_i | input | 1 | Transmitter enable |
| sw_mode_i | input | 1 | 1: software refill, 0: hardware refill |
| ext_size_i | input | 1 | 1: 256-entry wrap, 0: 128-entry wrap |
| hst_req_i | input | 1 | Register access strobe, one cycle |
| hst_we_i | input | 1 | 1: write, 0: read |
| hst_kind_i | input | 2 | 0 hold, 1 pointer, 2 buffer via pointer, 3 buffer direct |
| hst_addr_i | input | 8 | Address for direct buffer access |
| hst_wdata_i | input | 8 | Write data |
| hst_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_clr_i | input | 1 | Clears the refill interrupt |
| irq_o | output | 1 | Refill interrupt request |
| underrun_o | output | 1 | Sticky missed-refill flag |
| sda_oe_o | output | 1 | Data line drive enable, 0 = released |
| sda_do_o | output | 1 | Data line value when driven |

## Verification
The bench uses the defaults: 8-bit bytes, a 256-entry buffer, a two-stage synchronizer and a nine-edge preamble. Because the buffer is full size, both wrap settings can be reached in a few bytes by starting the pointer just below 127 or 255. The host side can also reach entry 200, which sits above the short window. Random buffer contents and random hold bytes are mixed with directed sequences that wrap the pointer, skip a refill, and write the pointer in a mode where the write must be ignored.

// File: rtl/edid_tx_pkg.sv
package edid_tx_pkg;
  typedef enum logic [1:0] {
    HK_HOLD = 2'd0,
    HK_PTR  = 2'd1,
    HK_BUFP = 2'd2,
    HK_BUFD = 2'd3
  } hst_kind_e;
endpackage

// File: rtl/edid_vclk_sync.sv
module edid_vclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vclk_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], vclk_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/edid_buf.sv
module edid_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/edid_ptr.sv
module edid_ptr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] FULL_MASK  = '1;
  localparam logic [AW-1:0] SHORT_MASK = FULL_MASK >> 1;

  logic [AW-1:0] mask;
  assign mask = ext_i ? FULL_MASK : SHORT_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i & mask;
    else if (inc_i)  ptr_o <= (ptr_o + 1'b1) & mask;
  end
endmodule

// File: rtl/edid_tx_seq.sv
module edid_tx_seq #(
  parameter int DW        = 8,
  parameter int SYNC_CLKS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sw_i,
  input  logic          vrise_i,
  input  logic [DW-1:0] fetch_data_i,
  input  logic          hold_wr_i,
  input  logic [DW-1:0] hold_wdata_i,
  input  logic          irq_clr_i,
  output logic          fetch_o,
  output logic [DW-1:0] hold_o,
  output logic          in_sync_o,
  output logic          sda_oe_o,
  output logic          sda_do_o,
  output logic          irq_o,
  output logic          underrun_o
);
  localparam int CW = $clog2(SYNC_CLKS + 1);
  localparam int SW = $clog2(DW + 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CLKS - 1);
  localparam logic [SW-1:0] SLOT_GAP  = SW'(DW);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slot_q, nslot;
  logic [DW-1:0] shift_q;
  logic          fresh_q;

  assign nslot   = (slot_q == SLOT_GAP) ? '0 : slot_q + 1'b1;
  assign fetch_o = en_i && vrise_i && !sw_i &&
                   ((in_sync_o && cnt_q == '0) || (!in_sync_o && nslot == SLOT_GAP));
  assign sda_do_o = shift_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      slot_q     <= SLOT_GAP;
      shift_q    <= '0;
      hold_o     <= '0;
      fresh_q    <= 1'b0;
      in_sync_o  <= 1'b1;
      sda_oe_o   <= 1'b0;
      irq_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q      <= '0;
      slot_q     <= SLOT_GAP;
      fresh_q    <= 1'b0;
      in_sync_o  <= 1'b1;
      sda_oe_o   <= 1'b0;
      irq_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (irq_clr_i) irq_o <= 1'b0;
      if (vrise_i) begin
        if (in_sync_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (fetch_o) hold_o <= fetch_data_i;
          if (cnt_q == SYNC_LAST) begin
            in_sync_o <= 1'b0;
            if (sw_i) irq_o <= 1'b1;
          end
        end else begin
          slot_q <= nslot;
          if (nslot == '0) begin
            shift_q  <= hold_o;
            sda_oe_o <= 1'b1;
            fresh_q  <= 1'b0;
            if (sw_i && !fresh_q) underrun_o <= 1'b1;
          end else if (nslot == SLOT_GAP) begin
            sda_oe_o <= 1'b0;
            if (fetch_o) hold_o <= fetch_data_i;
            if (sw_i)    irq_o  <= 1'b1;
          end else begin
            shift_q <= shift_q << 1;
          end
        end
      end
      // host refill counts toward the next byte start
      if (hold_wr_i && sw_i) begin
        hold_o  <= hold_wdata_i;
        fresh_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edid_serial_tx.sv
module edid_serial_tx
  import edid_tx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEPTH       = 256,
  parameter int SYNC_CLKS   = 9,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vclk_i,
  input  logic          en_i,
  input  logic          sw_mode_i,
  input  logic          ext_size_i,
  input  logic          hst_req_i,
  input  logic          hst_we_i,
  input  logic [1:0]    hst_kind_i,
  input  logic [AW-1:0] hst_addr_i,
  input  logic [DW-1:0] hst_wdata_i,
  output logic [DW-1:0] hst_rdata_o,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic          underrun_o,
  output logic          sda_oe_o,
  output logic          sda_do_o
);
  hst_kind_e     kind;
  logic          vrise, in_sync, fetch;
  logic          host_ok, hold_wr, ptr_wr, bufp, bufd, mem_we;
  logic [AW-1:0] ptr_q, mem_waddr;
  logic [DW-1:0] rd_ptr, rd_dir, hold;

  assign kind    = hst_kind_e'(hst_kind_i);
  assign host_ok = !en_i || sw_mode_i;
  assign hold_wr = hst_req_i && hst_we_i && kind == HK_HOLD && en_i && sw_mode_i;
  assign ptr_wr  = hst_req_i && hst_we_i && kind == HK_PTR && host_ok;
  assign bufp    = hst_req_i && kind == HK_BUFP && host_ok;
  assign bufd    = hst_req_i && kind == HK_BUFD;
  assign mem_we  = hst_we_i && (bufp || bufd);
  assign mem_waddr = bufp ? ptr_q : hst_addr_i;

  edid_vclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .vclk_i, .rise_o(vrise)
  );

  edid_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i,
    .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(hst_wdata_i),
    .raddr_a_i(ptr_q), .rdata_a_o(rd_ptr),
    .raddr_b_i(hst_addr_i), .rdata_b_o(rd_dir)
  );

  edid_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni, .ext_i(ext_size_i),
    .load_i(ptr_wr), .load_val_i(hst_wdata_i[AW-1:0]),
    .inc_i(fetch || bufp), .ptr_o(ptr_q)
  );

  edid_tx_seq #(.DW(DW), .SYNC_CLKS(SYNC_CLKS)) u_seq (
    .clk_i, .rst_ni, .en_i, .sw_i(sw_mode_i), .vrise_i(vrise),
    .fetch_data_i(rd_ptr), .hold_wr_i(hold_wr), .hold_wdata_i(hst_wdata_i),
    .irq_clr_i, .fetch_o(fetch), .hold_o(hold), .in_sync_o(in_sync),
    .sda_oe_o, .sda_do_o, .irq_o, .underrun_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hst_rdata_o <= '0;
    else if (hst_req_i && !hst_we_i) begin
      unique case (kind)
        HK_HOLD: hst_rdata_o <= hold;
        HK_PTR:  hst_rdata_o <= DW'(ptr_q);
        HK_BUFP: hst_rdata_o <= rd_ptr;
        HK_BUFD: hst_rdata_o <= rd_dir;
        default: hst_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/edid_serial_tx_chk.sv
module edid_serial_tx_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          vrise,
  input logic          in_sync,
  input logic [AW-1:0] ptr_q,
  input logic          hst_req_i,
  input logic [1:0]    hst_kind_i,
  input logic          irq_clr_i,
  input logic          irq_o,
  input logic          underrun_o,
  input logic          sda_oe_o,
  input logic          sda_do_o
);
  a_r1_released_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o);

  a_r2_quiet_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync |-> !sda_oe_o);

  a_r3_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && !vrise) |=> $stable(sda_do_o));

  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i && en_i) |=> (irq_o || !en_i));

  a_r9_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && en_i) |=> (underrun_o || !en_i));

  a_r12_direct_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_req_i && hst_kind_i == 2'd3 && !en_i) |=> $stable(ptr_q));
endmodule

bind edid_serial_tx edid_serial_tx_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .vrise(vrise),
  .in_sync(in_sync), .ptr_q(ptr_q), .hst_req_i(hst_req_i),
  .hst_kind_i(hst_kind_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o),
  .underrun_o(underrun_o), .sda_oe_o(sda_oe_o), .sda_do_o(sda_do_o)
);

// File: tb/edid_serial_tx_tb.sv
module edid_serial_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk = 1'b0, en = 1'b0, sw = 1'b0, ext = 1'b0;
  logic       req = 1'b0, we = 1'b0, irq_clr = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [7:0] addr = 8'd0, wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, underrun, oe, dout;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [256];

  always #2.5 clk = ~clk;

  edid_serial_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vclk_i(vclk), .en_i(en),
    .sw_mode_i(sw), .ext_size_i(ext), .hst_req_i(req), .hst_we_i(we),
    .hst_kind_i(kind), .hst_addr_i(addr), .hst_wdata_i(wdata),
    .hst_rdata_o(rdata), .irq_clr_i(irq_clr), .irq_o(irq),
    .underrun_o(underrun), .sda_oe_o(oe), .sda_do_o(dout)
  );

  function automatic logic [7:0] wrap_inc(logic [7:0] p, logic e);
    return (p + 8'd1) & (e ? 8'hFF : 8'h7F);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host(logic [1:0] k, logic w, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; kind = k; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // one vclk period; outputs sampled while vclk is high
  task automatic vpulse();
    @(negedge clk); vclk = 1'b1;
    repeat (6) @(negedge clk);
  endtask
  task automatic vlow();
    repeat (4) @(negedge clk); vclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic preamble(string tag);
    for (int i = 0; i < 9; i++) begin
      vpulse(); chk(tag, {7'd0, oe}, 8'd0); vlow();
    end
  endtask

  task automatic byte_out(logic [7:0] exp, string tag);
    for (int b = 7; b >= 0; b--) begin
      vpulse();
      chk({tag, " R3 drive"}, {7'd0, oe}, 8'd1);
      chk({tag, " R3 bit"}, {7'd0, dout}, {7'd0, exp[b]});
      vlow();
    end
    vpulse(); chk("R4 gap released", {7'd0, oe}, 8'd0);
  endtask

  initial begin
    logic [7:0] p, h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 oe", {7'd0, oe}, 8'd0);
    chk("R13 irq", {7'd0, irq}, 8'd0);
    chk("R13 underrun", {7'd0, underrun}, 8'd0);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R13 ptr", rdata, 8'd0);

    for (int i = 0; i < 256; i++) begin
      mdl[i] = 8'($urandom);
      host(2'd3, 1'b1, 8'(i), mdl[i]);
    end

    // R1 while disabled vclk has no effect on the line
    vpulse(); chk("R1 off", {7'd0, oe}, 8'd0); vlow();

    // hardware mode, short window
    ext = 1'b0; sw = 1'b0;
    host(2'd1, 1'b1, 8'd0, 8'd125);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R10 ptr write", rdata, 8'd125);
    en = 1'b1;
    preamble("R2 preamble");
    p = 8'd125;
    for (int n = 0; n < 5; n++) begin
      byte_out(mdl[p], "R5 R6 hw short");
      vlow();
      p = wrap_inc(p, 1'b0);
    end
    // 6 fetches so far: 125 + 6 wraps to 3
    host(2'd1, 1'b1, 8'd0, 8'd50);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R10 ignored in hw", rdata, 8'd3);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 disabled", {7'd0, oe}, 8'd0);
    host(2'd3, 1'b0, 8'd200, 8'd0);
    chk("R12 direct read", rdata, mdl[200]);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R12 ptr kept", rdata, 8'd3);

    // hardware mode, full window
    ext = 1'b1;
    host(2'd1, 1'b1, 8'd0, 8'd253);
    en = 1'b1;
    preamble("R2 preamble full");
    p = 8'd253;
    for (int n = 0; n < 4; n++) begin
      byte_out(mdl[p], "R5 R6 hw full");
      vlow();
      p = wrap_inc(p, 1'b1);
    end
    en = 1'b0;

    // software mode: pointer accesses
    ext = 1'b0; sw = 1'b1;
    host(2'd1, 1'b1, 8'd0, 8'd126);
    host(2'd2, 1'b0, 8'd0, 8'd0);
    chk("R11 read via ptr", rdata, mdl[126]);
    host(2'd2, 1'b0, 8'd0, 8'd0);
    chk("R11 read via ptr", rdata, mdl[127]);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R11 R6 wrap", rdata, 8'd0);
    h = 8'($urandom);
    host(2'd2, 1'b1, 8'd0, h);
    mdl[0] = h;
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R11 post inc", rdata, 8'd1);
    host(2'd3, 1'b0, 8'd0, 8'd0);
    chk("R11 write via ptr", rdata, h);
    host(2'd1, 1'b1, 8'd0, 8'd200);
    host(2'd1, 1'b0, 8'd0, 8'd0);
    chk("R10 masked write", rdata, 8'd72);

    // software mode: interrupt-driven refill
    en = 1'b1;
    for (int i = 0; i < 8; i++) begin vpulse(); vlow(); end
    chk("R7 no irq before sync end", {7'd0, irq}, 8'd0);
    vpulse();
    chk("R7 irq at sync end", {7'd0, irq}, 8'd1);
    vlow();
    for (int n = 0; n < 6; n++) begin
      h = (n == 0) ? 8'hA5 : 8'($urandom);
      host(2'd0, 1'b1, 8'd0, h);
      clr_irq();
      chk("R7 irq cleared", {7'd0, irq}, 8'd0);
      byte_out(h, "R8 sw byte");
      chk("R7 irq at gap", {7'd0, irq}, 8'd1);
      vlow();
    end
    chk("R9 no underrun yet", {7'd0, underrun}, 8'd0);
    clr_irq();
    byte_out(h, "R9 resend");
    chk("R9 underrun set", {7'd0, underrun}, 8'd1);
    vlow();
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 underrun cleared off", {7'd0, underrun}, 8'd0);
    chk("R7 irq cleared off", {7'd0, irq}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule